// File: doc/BRIEF.md
# Display Link Training Sequencer

This block sequences the two training phases of a serial display link. After a start pulse it puts the clock-recovery pattern on the transmitter and in the sink, then repeats one loop: ask a neighbouring drive-adjust encoder to commit new drive levels, wait a settling interval, read the sink's status block, and judge each active lane. Once every lane has clock recovery, it moves to equalization with the richest pattern the sink supports. It repeats the same loop there until the lanes are equalized, symbol-locked and aligned, or until a limit is reached. In every case it finishes by restoring the idle pattern. It then pulses `done`, and `pass` holds the result.

All sink accesses go through a one-byte register request port, which holds a request until it is acknowledged. The transaction engine behind that port lives outside this block. The sink's capabilities (read-interval field, pattern-3 support) and the lane count are sampled at start. The settling intervals are cycle counts set by parameters.

Top module: `link_train_seq`

## Requirements
- R1: On `start` the block reads the sink pattern register at `REG_PATTERN`. It writes the register back with bits [1:0] set to 1 and bits [7:2] unchanged, and drives `tx_pattern` = 1 before that write.
- R2: Each loop commits drive levels through `adj_req`, which is held until `adj_ack`. It then reads six status bytes at `REG_STATUS`+0..+5 in rising address order. `reg_req` holds its address and direction until `reg_ack`. `reg_req` and `adj_req` are never high together. `adj_status` shows {byte 5, byte 4} of the last status read.
- R3: The wait from an acknowledge to the first status read request is `rd_interval`*`MS4_CYC`+2 cycles when `rd_interval` is nonzero. Otherwise it is `CR_WAIT_CYC`+2 in clock recovery and `EQ_WAIT_CYC`+2 in equalization.
- R4: Lane i's status nibble is bits [4(i&1)+3 : 4(i&1)] of status byte i>>1: bit 0 is CR done, bit 1 is EQ done and bit 2 is symbol locked. Lanes at or above `lane_cnt` are ignored. Clock recovery passes when every active lane has CR done.
- R5: Clock recovery fails at once when the lowest active lane without CR done has its bit set in the `adj_maxsw` value returned by the last commit.
- R6: The clock-recovery try count restarts whenever the lane-0 swing `adj_swing0` from the last commit differs from the previous one (initially 0). Clock recovery fails after 5 loops at one swing.
- R7: Equalization uses pattern 3 when `tps3_cap` is set and pattern 2 otherwise, written as in R1. With pattern 3, `adj_pc` is high with each equalization commit and the byte at `REG_PCSTAT` is read after each status block. Otherwise `adj_pc` stays low and that byte is not read.
- R8: The first equalization loop skips the drive commit.
- R9: Equalization passes only when bit 0 of status byte 2 (interlane alignment) is set and every active lane has both EQ done and symbol locked.
- R10: Equalization fails as soon as an active lane lacks CR done, or after the sixth status read without success.
- R11: An error on the post-cursor read sets `adj_pcstat` to 0x00, and training continues.
- R12: Any other port error or an `adj_err` ends training as failed. Whether training passes or fails, pattern 0 is then written as in R1 and `tx_pattern` is 0. `done` pulses for one cycle with `pass` valid.
- R13: The status bytes and post-cursor status are cleared at start, so the first commit sees `adj_status` = 0 and `adj_pcstat` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (ignored while busy) |
| lane_cnt | input | LC_W | Number of active lanes |
| rd_interval | input | 8 | Sink read-interval field, in 4 ms units |
| tps3_cap | input | 1 | Sink supports training pattern 3 |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Access complete |
| reg_err | input | 1 | Access failed (valid with ack) |
| reg_rdata | input | 8 | Read data (valid with ack) |
| adj_req | output | 1 | Commit drive levels request |
| adj_pc | output | 1 | Post-cursor handling requested |
| adj_status | output | 8*NB | Adjust-request status bytes |
| adj_pcstat | output | 8 | Post-cursor status byte |
| adj_ack | input | 1 | Commit complete |
| adj_err | input | 1 | Commit failed (valid with ack) |
| adj_swing0 | input | 2 | Lane-0 swing chosen by the commit |
| adj_maxsw | input | LANES | Per-lane max-swing flags of the commit |
| tx_pattern | output | 2 | Pattern on the transmitter |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last run |

## Verification
A wrong try count or swing comparison appears at the ports as a different number of `adj_req` handshakes before the final pattern write, which shows up within one loop of the divergence. A wrong lane decode or mask flips `pass`, or it shortens or lengthens the sequence of status reads. The bench sees this at the first status block the design misjudges. A wrong wait target changes the gap between an acknowledge and the next status request, which is caught in that same loop. A missed clear, or an omitted post-cursor zeroing, appears in `adj_status`/`adj_pcstat` at the very next commit.

// File: rtl/ltseq_pkg.sv
package ltseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PAT_RD,
        S_PAT_WR,
        S_COMMIT,
        S_WAIT,
        S_ST_RD,
        S_PC_RD,
        S_EVAL,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_CR,
        PH_EQ,
        PH_END
    } phase_e;

    localparam int CR_TRY_MAX = 5;
    localparam int EQ_TRY_MAX = 5;

    // nibble bit positions in a lane status nibble
    localparam int NIB_CR   = 0;
    localparam int NIB_EQ   = 1;
    localparam int NIB_LOCK = 2;

    typedef struct packed {
        logic cr_lost;   // some active lane lacks CR done
        logic eq_all;    // aligned and every active lane equalized and locked
        logic stuck;     // lowest unfinished lane already at max swing
    } lane_verdict_t;

    function automatic logic [7:0] merge_pattern(input logic [7:0] old, input logic [1:0] pat);
        return {old[7:2], pat};
    endfunction

endpackage

// File: rtl/lane_eval.sv
module lane_eval
    import ltseq_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LC_W = $clog2(LANES + 1)
) (
    input  logic [LANES*4-1:0] nib,
    input  logic [LC_W-1:0]    lane_cnt,
    input  logic               align,
    input  logic [LANES-1:0]   max_flag,
    output lane_verdict_t      verdict
);

    logic [LANES-1:0] cr_miss;
    logic [LANES-1:0] eq_miss;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic active;
            assign active     = (LC_W'(i) < lane_cnt);
            assign cr_miss[i] = active && !nib[4*i + NIB_CR];
            assign eq_miss[i] = active && !(nib[4*i + NIB_EQ] && nib[4*i + NIB_LOCK]);
        end
    endgenerate

    always_comb begin
        logic found;
        found         = 1'b0;
        verdict.stuck = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (cr_miss[i] && !found) begin
                found         = 1'b1;
                verdict.stuck = max_flag[i];
            end
        end
        verdict.cr_lost = |cr_miss;
        verdict.eq_all  = align && !(|eq_miss);
    end

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] target,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= target;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
    import ltseq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ADDR_W = 20,
    parameter logic [ADDR_W-1:0] REG_PATTERN = 20'h00102,
    parameter logic [ADDR_W-1:0] REG_STATUS  = 20'h00202,
    parameter logic [ADDR_W-1:0] REG_PCSTAT  = 20'h0020C,
    parameter int CR_WAIT_CYC = 8,
    parameter int EQ_WAIT_CYC = 20,
    parameter int MS4_CYC = 16,
    parameter int CNT_W = 24,
    localparam int LC_W = $clog2(LANES + 1),
    localparam int NB = (LANES + 1) / 2,
    localparam int STAT_N = 2 * NB + 2,
    localparam int IDX_W = $clog2(STAT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LC_W-1:0]   lane_cnt,
    input  logic [7:0]        rd_interval,
    input  logic              tps3_cap,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic              reg_ack,
    input  logic              reg_err,
    input  logic [7:0]        reg_rdata,
    output logic              adj_req,
    output logic              adj_pc,
    output logic [8*NB-1:0]   adj_status,
    output logic [7:0]        adj_pcstat,
    input  logic              adj_ack,
    input  logic              adj_err,
    input  logic [1:0]        adj_swing0,
    input  logic [LANES-1:0]  adj_maxsw,
    output logic [1:0]        tx_pattern,
    output logic              busy,
    output logic              done,
    output logic              pass
);

    seq_state_e        state;
    phase_e            phase;
    logic [1:0]        pat_sel;
    logic [7:0]        pat_old;
    logic [2:0]        tries;
    logic [1:0]        prev_swing, cur_swing;
    logic [LANES-1:0]  cur_maxsw;
    logic [7:0]        stat [STAT_N];
    logic [7:0]        pcstat;
    logic [IDX_W-1:0]  byte_idx;
    logic [LC_W-1:0]   lanes_q;
    logic [7:0]        rd_q;
    logic              tps3_q;
    logic              pass_q;

    // ---------------- lane judgement ----------------
    logic [8*NB-1:0] lane_bytes;
    lane_verdict_t   verdict;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_lb
            assign lane_bytes[8*b +: 8]  = stat[b];
            assign adj_status[8*b +: 8]  = stat[NB + 2 + b];
        end
    endgenerate

    lane_eval #(.LANES(LANES)) u_eval (
        .nib      (lane_bytes[LANES*4-1:0]),
        .lane_cnt (lanes_q),
        .align    (stat[NB][0]),
        .max_flag (cur_maxsw),
        .verdict  (verdict)
    );

    // ---------------- settle timer ----------------
    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_target;

    always_comb begin
        if (rd_q != 8'd0)
            tmr_target = CNT_W'(rd_q) * CNT_W'(MS4_CYC);
        else if (phase == PH_EQ)
            tmr_target = CNT_W'(EQ_WAIT_CYC);
        else
            tmr_target = CNT_W'(CR_WAIT_CYC);
    end

    assign tmr_load = (state == S_COMMIT && adj_ack && !adj_err) ||
                      (state == S_PAT_WR && reg_ack && !reg_err && phase == PH_EQ);

    settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .target  (tmr_target),
        .expired (tmr_exp)
    );

    // ---------------- port outputs ----------------
    logic pc_on;
    assign pc_on = (phase == PH_EQ) && (pat_sel == 2'd3);

    always_comb begin
        reg_req   = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = REG_PATTERN;
        reg_wdata = 8'h00;
        unique case (state)
            S_PAT_RD: reg_req = 1'b1;
            S_PAT_WR: begin
                reg_req   = 1'b1;
                reg_wr    = 1'b1;
                reg_wdata = merge_pattern(pat_old, pat_sel);
            end
            S_ST_RD: begin
                reg_req  = 1'b1;
                reg_addr = REG_STATUS + ADDR_W'(byte_idx);
            end
            S_PC_RD: begin
                reg_req  = 1'b1;
                reg_addr = REG_PCSTAT;
            end
            default: ;
        endcase
    end

    assign adj_req    = (state == S_COMMIT);
    assign adj_pc     = adj_req && pc_on;
    assign adj_pcstat = pcstat;
    assign busy       = (state != S_IDLE);
    assign done       = (state == S_DONE);
    assign pass       = pass_q;

    // ---------------- sequencer ----------------
    logic [2:0] cr_next, eq_next;
    assign cr_next = (cur_swing != prev_swing) ? 3'd1 : tries + 3'd1;
    assign eq_next = tries + 3'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            phase      <= PH_CR;
            pat_sel    <= 2'd0;
            pat_old    <= 8'h00;
            tries      <= 3'd0;
            prev_swing <= 2'd0;
            cur_swing  <= 2'd0;
            cur_maxsw  <= '0;
            pcstat     <= 8'h00;
            byte_idx   <= '0;
            lanes_q    <= '0;
            rd_q       <= 8'h00;
            tps3_q     <= 1'b0;
            pass_q     <= 1'b0;
            tx_pattern <= 2'd0;
            for (int k = 0; k < STAT_N; k++) stat[k] <= 8'h00;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    for (int k = 0; k < STAT_N; k++) stat[k] <= 8'h00;
                    pcstat     <= 8'h00;
                    tries      <= 3'd0;
                    prev_swing <= 2'd0;
                    cur_swing  <= 2'd0;
                    cur_maxsw  <= '0;
                    lanes_q    <= lane_cnt;
                    rd_q       <= rd_interval;
                    tps3_q     <= tps3_cap;
                    pass_q     <= 1'b0;
                    phase      <= PH_CR;
                    pat_sel    <= 2'd1;
                    tx_pattern <= 2'd1;
                    state      <= S_PAT_RD;
                end
                S_PAT_RD: if (reg_ack) begin
                    if (reg_err) begin
                        if (phase == PH_END) state <= S_DONE;
                        else begin
                            phase <= PH_END; pat_sel <= 2'd0; tx_pattern <= 2'd0; state <= S_PAT_RD;
                        end
                    end else begin
                        pat_old <= reg_rdata;
                        state   <= S_PAT_WR;
                    end
                end
                S_PAT_WR: if (reg_ack) begin
                    if (phase == PH_END) state <= S_DONE;
                    else if (reg_err) begin
                        phase <= PH_END; pat_sel <= 2'd0; tx_pattern <= 2'd0; state <= S_PAT_RD;
                    end else if (phase == PH_CR) state <= S_COMMIT;
                    else state <= S_WAIT;
                end
                S_COMMIT: if (adj_ack) begin
                    if (adj_err) begin
                        phase <= PH_END; pat_sel <= 2'd0; tx_pattern <= 2'd0; state <= S_PAT_RD;
                    end else begin
                        cur_swing <= adj_swing0;
                        cur_maxsw <= adj_maxsw;
                        state     <= S_WAIT;
                    end
                end
                S_WAIT: if (tmr_exp) begin
                    byte_idx <= '0;
                    state    <= S_ST_RD;
                end
                S_ST_RD: if (reg_ack) begin
                    if (reg_err) begin
                        phase <= PH_END; pat_sel <= 2'd0; tx_pattern <= 2'd0; state <= S_PAT_RD;
                    end else begin
                        stat[byte_idx] <= reg_rdata;
                        if (byte_idx == IDX_W'(STAT_N - 1)) state <= pc_on ? S_PC_RD : S_EVAL;
                        else byte_idx <= byte_idx + 1'b1;
                    end
                end
                S_PC_RD: if (reg_ack) begin
                    pcstat <= reg_err ? 8'h00 : reg_rdata;
                    state  <= S_EVAL;
                end
                S_EVAL: begin
                    if (phase == PH_CR) begin
                        if (!verdict.cr_lost) begin
                            phase      <= PH_EQ;
                            pat_sel    <= tps3_q ? 2'd3 : 2'd2;
                            tx_pattern <= tps3_q ? 2'd3 : 2'd2;
                            tries      <= 3'd0;
                            state      <= S_PAT_RD;
                        end else if (verdict.stuck || cr_next >= 3'(CR_TRY_MAX)) begin
                            phase <= PH_END; pat_sel <= 2'd0; tx_pattern <= 2'd0; state <= S_PAT_RD;
                        end else begin
                            prev_swing <= cur_swing;
                            tries      <= cr_next;
                            state      <= S_COMMIT;
                        end
                    end else begin
                        if (verdict.eq_all || verdict.cr_lost || eq_next > 3'(EQ_TRY_MAX)) begin
                            pass_q <= verdict.eq_all;
                            phase <= PH_END; pat_sel <= 2'd0; tx_pattern <= 2'd0; state <= S_PAT_RD;
                        end else begin
                            tries <= eq_next;
                            state <= S_COMMIT;
                        end
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_hold_req_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_wr)));

    assert_ports_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(reg_req && adj_req));

    assert_pc_needs_p3_R7: assert property (@(posedge clk) disable iff (rst)
        adj_pc |-> (tx_pattern == 2'd3));

    assert_cr_tries_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CR) |-> (tries < 3'(CR_TRY_MAX)));

    assert_eq_tries_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EQ) |-> (tries <= 3'(EQ_TRY_MAX)));

    assert_done_idle_pattern_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> (tx_pattern == 2'd0 && !reg_req && !adj_req));

endmodule

// File: tb/link_train_seq_bench.sv
module link_train_seq_bench;

    localparam int PERIOD = 10;
    localparam int LANES = 4;
    localparam int ADDR_W = 20;
    localparam logic [ADDR_W-1:0] A_PAT = 20'h00102;
    localparam logic [ADDR_W-1:0] A_ST  = 20'h00202;
    localparam logic [ADDR_W-1:0] A_PC  = 20'h0020C;
    localparam int CRW = 8, EQW = 20, MS4 = 16;

    logic clk = 0, rst = 1, start = 0;
    logic [2:0] lane_cnt = 3'd1;
    logic [7:0] rd_interval = 0;
    logic tps3_cap = 0;
    logic reg_req, reg_wr, reg_ack = 0, reg_err = 0;
    logic [ADDR_W-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata = 0;
    logic adj_req, adj_pc, adj_ack = 0, adj_err = 0;
    logic [15:0] adj_status;
    logic [7:0] adj_pcstat;
    logic [1:0] adj_swing0 = 0;
    logic [3:0] adj_maxsw = 0;
    logic [1:0] tx_pattern;
    logic busy, done, pass;

    always #(PERIOD/2) clk = ~clk;

    link_train_seq u_link_train_seq (
        .clk(clk), .rst(rst), .start(start), .lane_cnt(lane_cnt),
        .rd_interval(rd_interval), .tps3_cap(tps3_cap),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
        .adj_req(adj_req), .adj_pc(adj_pc), .adj_status(adj_status), .adj_pcstat(adj_pcstat),
        .adj_ack(adj_ack), .adj_err(adj_err), .adj_swing0(adj_swing0), .adj_maxsw(adj_maxsw),
        .tx_pattern(tx_pattern), .busy(busy), .done(done), .pass(pass)
    );

    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scenario data
    logic [15:0] lanes_arr [16];
    bit          align_arr [16];
    logic [1:0]  sw_arr [16];
    logic [3:0]  mx_arr [16];
    int  err_idx = -1;
    bit  pc_err = 0;
    bit  clr = 0;

    // sink model
    int n_stat = 0, n_pc = 0;
    logic [7:0] sink_pat = 8'hA4;
    int pat_log [$];
    always @(posedge clk) begin
        int k, si;
        if (clr) begin
            n_stat <= 0; n_pc <= 0; sink_pat <= 8'hA4; reg_ack <= 0; reg_err <= 0;
        end else if (reg_req && !reg_ack) begin
            reg_ack <= 1; reg_err <= 0; reg_rdata <= 8'h00;
            if (reg_wr) begin
                if (reg_addr == A_PAT) sink_pat <= reg_wdata;
            end else if (reg_addr == A_PAT) begin
                reg_rdata <= sink_pat;
            end else if (reg_addr == A_PC) begin
                n_pc <= n_pc + 1;
                reg_err <= pc_err;
                reg_rdata <= 8'h3C;
            end else begin
                k = int'(reg_addr) - int'(A_ST);
                si = (k == 0) ? n_stat : n_stat - 1;
                if (k == 0) n_stat <= n_stat + 1;
                if (k == 0 && si == err_idx) reg_err <= 1;
                case (k)
                    0: reg_rdata <= lanes_arr[si][7:0];
                    1: reg_rdata <= lanes_arr[si][15:8];
                    2: reg_rdata <= {7'd0, align_arr[si]};
                    4: reg_rdata <= 8'hC3;
                    5: reg_rdata <= 8'(si);
                    default: reg_rdata <= 8'h00;
                endcase
            end
        end else begin
            reg_ack <= 0; reg_err <= 0;
        end
    end

    // drive-adjust encoder model
    int n_com = 0;
    always @(posedge clk) begin
        if (clr) begin
            n_com <= 0; adj_ack <= 0;
        end else if (adj_req && !adj_ack) begin
            adj_ack <= 1; adj_err <= 0;
            adj_swing0 <= sw_arr[n_com];
            adj_maxsw  <= mx_arr[n_com];
            n_com <= n_com + 1;
        end else adj_ack <= 0;
    end

    // per-clock observation
    int cyc = 0, t_ack = -1;
    bit in_eq = 0;
    always @(negedge clk) begin
        int exp_t;
        cyc++;
        if (!rst && !clr) begin
            if (adj_req && !adj_ack) begin
                chk(adj_status == ((n_stat == 0) ? 16'h0000 : {8'(n_stat - 1), 8'hC3}),
                    "R2/R13 adj_status", int'(adj_status), n_stat);
                chk(adj_pcstat == ((n_pc == 0 || pc_err) ? 8'h00 : 8'h3C),
                    "R11/R13 adj_pcstat", int'(adj_pcstat), 0);
                chk(adj_pc == (in_eq && tps3_cap), "R7 adj_pc", int'(adj_pc), int'(in_eq && tps3_cap));
            end
            chk(!(reg_req && adj_req), "R2 exclusive", int'(reg_req), 0);
            if (adj_ack) t_ack = cyc;
            if (reg_req && reg_wr && !reg_ack && reg_addr == A_PAT) begin
                pat_log.push_back(int'(reg_wdata));
                chk(tx_pattern == reg_wdata[1:0], "R1 tx_pattern", int'(tx_pattern), int'(reg_wdata[1:0]));
                in_eq = (reg_wdata[1:0] >= 2'd2);
            end
            if (reg_req && !reg_wr && !reg_ack && reg_addr == A_ST && t_ack >= 0) begin
                exp_t = (rd_interval != 0) ? int'(rd_interval) * MS4 : (in_eq ? EQW : CRW);
                chk(cyc - t_ack == exp_t + 2, "R3 wait", cyc - t_ack, exp_t + 2);
                t_ack = -1;
            end
        end
    end

    // reference model of the outcome
    int e_pass, e_com, e_rd, e_pc, e_cr;
    task automatic model();
        int j, c, tries, prev, lc, l;
        logic [15:0] v;
        bit stop, crok, lost, eqok;
        lc = int'(lane_cnt);
        j = 0; c = 0; tries = 0; prev = 0; crok = 0; stop = 0;
        e_pass = 0; e_pc = 0;
        while (!stop) begin
            c++;
            if (j == err_idx) begin j++; break; end
            v = lanes_arr[j]; j++;
            l = -1;
            for (int i = 0; i < lc; i++) if (l < 0 && !v[4*i]) l = i;
            if (l < 0) begin crok = 1; break; end
            if (mx_arr[c-1][l]) break;
            if (int'(sw_arr[c-1]) != prev) tries = 1; else tries++;
            prev = int'(sw_arr[c-1]);
            if (tries >= 5) break;
        end
        if (crok) begin
            tries = 0;
            while (1) begin
                if (tries > 0) c++;
                if (j == err_idx) begin j++; break; end
                v = lanes_arr[j];
                eqok = align_arr[j];
                j++;
                if (tps3_cap) e_pc++;
                lost = 0;
                for (int i = 0; i < lc; i++) begin
                    if (!v[4*i]) lost = 1;
                    if (!(v[4*i+1] && v[4*i+2])) eqok = 0;
                end
                if (eqok) begin e_pass = 1; break; end
                if (lost) break;
                tries++;
                if (tries > 5) break;
            end
        end
        e_com = c; e_rd = j; e_cr = crok;
    endtask

    task automatic run(input string name, input int lc, input bit t3, input int rd);
        int w;
        lane_cnt = 3'(lc); tps3_cap = t3; rd_interval = 8'(rd);
        clr = 1; pat_log.delete(); in_eq = 0; t_ack = -1;
        @(negedge clk); clr = 0;
        model();
        start = 1; @(negedge clk); start = 0;
        w = 0;
        while (!done && w < 5000) begin @(negedge clk); w++; end
        chk(w < 5000, {"R12 ", name, " timeout"}, w, 5000);
        chk(pass == e_pass, {"R9/R10 ", name, " pass"}, int'(pass), e_pass);
        chk(tx_pattern == 2'd0, {"R12 ", name, " final pattern"}, int'(tx_pattern), 0);
        @(negedge clk);
        chk(n_com == e_com, {"R5/R6/R8 ", name, " commits"}, n_com, e_com);
        chk(n_stat == e_rd, {"R4/R10 ", name, " status reads"}, n_stat, e_rd);
        chk(n_pc == e_pc, {"R7 ", name, " pc reads"}, n_pc, e_pc);
        chk(pat_log.size() == (e_cr ? 3 : 2), {"R12 ", name, " pattern writes"}, pat_log.size(), e_cr ? 3 : 2);
        if (pat_log.size() >= 2) begin
            chk(pat_log[0] == 'hA5, {"R1 ", name, " first write"}, pat_log[0], 'hA5);
            chk(pat_log[pat_log.size()-1] == 'hA4, {"R12 ", name, " last write"}, pat_log[pat_log.size()-1], 'hA4);
        end
        if (e_cr && pat_log.size() == 3)
            chk(pat_log[1] == (t3 ? 'hA7 : 'hA6), {"R7 ", name, " eq pattern"}, pat_log[1], t3 ? 'hA7 : 'hA6);
        chk(!busy, {"R12 ", name, " idle"}, int'(busy), 0);
    endtask

    task automatic fill(input logic [15:0] v, input bit al);
        for (int i = 0; i < 16; i++) begin
            lanes_arr[i] = v; align_arr[i] = al; sw_arr[i] = 0; mx_arr[i] = 0;
        end
        err_idx = -1; pc_err = 0;
    endtask

    initial begin
        fill(16'h0000, 0);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !reg_req && !adj_req && tx_pattern == 0, "R12 reset state", int'(busy), 0);

        // S1: R4 two lanes pass in one loop each phase, pattern 2
        fill(16'h0000, 0);
        lanes_arr[0] = 16'h0011; lanes_arr[1] = 16'h0077; align_arr[1] = 1;
        run("s1", 2, 0, 0);

        // S2: R6 swing change restarts count
        fill(16'h0000, 0);
        sw_arr[2] = 1; sw_arr[3] = 1; sw_arr[4] = 1; sw_arr[5] = 1; sw_arr[6] = 1; sw_arr[7] = 1;
        run("s2", 1, 0, 0);

        // S3: R5 max swing on unfinished lane 1 at second commit
        fill(16'h0001, 0);
        mx_arr[1] = 4'b0010;
        run("s3", 2, 0, 0);

        // S4: R7 R10 R11 pattern 3, six EQ reads, pc read errors, long interval
        fill(16'h3333, 0);
        lanes_arr[0] = 16'h1111; pc_err = 1;
        run("s4", 4, 1, 2);

        // S5: R10 lane 3 loses CR during EQ
        fill(16'h1111, 0);
        lanes_arr[1] = 16'h0111; align_arr[1] = 1;
        run("s5", 4, 0, 0);

        // S6: R9 alignment then lock needed, pattern 3 with pc status
        fill(16'h1111, 0);
        lanes_arr[1] = 16'h7777; align_arr[1] = 0;
        lanes_arr[2] = 16'h3777; align_arr[2] = 1;
        lanes_arr[3] = 16'h7777; align_arr[3] = 1;
        run("s6", 4, 1, 0);

        // S7: R12 status read error in CR
        fill(16'h1111, 0);
        err_idx = 0;
        run("s7", 1, 0, 0);

        // S8: R4 lanes beyond lane_cnt ignored
        fill(16'h0000, 0);
        lanes_arr[0] = 16'hEE01; lanes_arr[1] = 16'h8807; align_arr[1] = 1;
        run("s8", 1, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(PERIOD * 190000);
        n_checks++; n_fail++;
        $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule